// File: doc/BRIEF.md
# Two-Pattern Scan Path with Hold Stage

This block is a scan chain built for launching delay tests. Each scan flip-flop reaches the logic under test only through its own level-sensitive hold stage. While the hold control is high, that stage stays opaque. The chain can therefore shift in a second vector while the first vector is still applied to the logic. Because of this, any pair of vectors can be launched, not only pairs that the logic itself or a one-bit shift could produce.

A built-in sequencer walks one complete two-pattern test after a `start` pulse, in five phases:

1. It shifts in the first state vector.
2. It opens the hold stage so the first vector settles in the logic.
3. It closes the hold stage and shifts in the second vector.
4. It releases the second vector for exactly one clock period and captures the response at the end of that period.
5. It shifts the captured response out.

The primary-input values for the first and second vectors are switched in step with these phases. When the sequencer is idle, the scan mode, flip-flop enable and hold controls come straight from the pins, so the chain can also be driven by hand.

Top module: `enh_scan_path`

## Requirements
- R1: Under synchronous active-low reset all scan flip-flops clear to 0, and the sequencer goes idle with `busy`, `shift_req` and `unload_valid` low.
- R2: With scan mode selected and the flip-flop enable high, each clock moves `scan_in` into cell 0 and cell i into cell i+1. `scan_out` shows the last cell. After N shifts, the first bit fed sits in the last cell (bit N-1 of `to_logic`).
- R3: A cell loads its `from_logic` bit only when scan mode is off and the enable is high. In scan mode the `from_logic` value has no effect on the chain contents.
- R4: With the enable low, every scan flip-flop keeps its value whatever the mode and `from_logic`.
- R5: While hold is high, `to_logic` stays unchanged even as the flip-flops shift. While hold is low, `to_logic` equals the flip-flop contents.
- R6: A `start` pulse while idle raises `busy` and begins N cycles with `shift_req` high, during which `scan_in` is shifted in as the first vector.
- R7: After the first load, for SETTLE cycles, `to_logic` shows the first vector, with `shift_req` low and no shifting.
- R8: Next come N more `shift_req` cycles that shift in the second vector. Throughout them `to_logic` keeps the first vector.
- R9: A single launch cycle follows. In it `to_logic` shows the second vector and `pi_out` equals `pi_v2`. The response on `from_logic` is captured at the clock edge ending that cycle.
- R10: For the next N cycles `unload_valid` is high and `scan_out` gives the captured bits last cell first (bit N-1, then N-2, down to 0). After that the sequencer returns to idle.
- R11: `pi_out` equals `pi_v1` in every cycle except the launch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one two-pattern test (when idle) |
| man_scan | input | 1 | Scan-mode select used while idle |
| man_en | input | 1 | Flip-flop enable used while idle |
| man_hold | input | 1 | Hold control used while idle (1 = opaque) |
| scan_in | input | 1 | Serial scan data in |
| scan_out | output | 1 | Serial scan data out (last cell) |
| to_logic | output | N | Hold-stage outputs driving the logic under test |
| from_logic | input | N | Responses of the logic under test |
| pi_v1 | input | P | Primary-input values for the first vector |
| pi_v2 | input | P | Primary-input values for the second vector |
| pi_out | output | P | Primary inputs applied to the logic |
| busy | output | 1 | Sequencer is walking a test |
| shift_req | output | 1 | Sequencer consumes a `scan_in` bit this cycle |
| unload_valid | output | 1 | `scan_out` carries a captured bit this cycle |

## Verification
The bench builds the block with N = 8 cells, P = 4 primary inputs and SETTLE = 2. A behavioural model of the logic under test sits around it: the logic rotates the chain outputs and XORs the primary inputs into both halves. With this setting a full walk takes only about 27 cycles, so several vector pairs fit in the run. The pairs include ones whose second vector cannot be reached from the first by any one-bit shift. Because the response depends on the primary inputs, a wrong switch between `pi_v1` and `pi_v2` shows up in the unloaded bits. The two-cycle settle window makes it possible to check that the first vector stays visible for more than one cycle.

// File: rtl/esp_pkg.sv
// Package: shared types for the two-pattern scan path.
// Assumes: imported by the sequencer and the top module.
package esp_pkg;

    // Sequencer phases of one two-pattern test
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD1  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_LOAD2  = 3'd3,
        ST_LAUNCH = 3'd4,
        ST_UNLOAD = 3'd5
    } seq_state_e;

    // Control bundle applied to every cell
    typedef struct packed {
        logic scan;    // 1 = serial shift, 0 = parallel capture
        logic en;      // flip-flop update enable
        logic hold;    // 1 = hold stage opaque
        logic pi_sel2; // 1 = apply second-vector primary inputs
    } chain_ctrl_t;

endpackage

// File: rtl/esp_cell.sv
// Module: one scan cell, made of a flip-flop with a shift/capture/keep choice
// feeding a level-sensitive hold stage.
// Assumes: hold changes only away from the point where it must be stable.
module esp_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic scan,
    input  logic en,
    input  logic hold,
    input  logic si,
    input  logic pi,
    output logic ff_q,
    output logic lat_q
);

    // Flip-flop: shift in scan mode, capture in normal mode, keep when disabled
    always_ff @(posedge clk) begin
        if (!rst_n)     ff_q <= 1'b0;
        else if (en)    ff_q <= scan ? si : pi;
    end

    // Hold stage: transparent while hold is low, opaque while high
    always_latch begin
        if (!hold) lat_q = ff_q;
    end

    // R2
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && en) |=> (ff_q == $past(si)));

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan && en) |=> (ff_q == $past(pi)));

    // R4
    keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(ff_q));

endmodule

// File: rtl/esp_seq.sv
// Module: sequencer that walks one two-pattern test: load V1, settle,
// load V2 under hold, launch-and-capture, unload.
// Assumes: start is sampled only while idle.
module esp_seq #(
    parameter int N      = 8,
    parameter int SETTLE = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output esp_pkg::chain_ctrl_t ctrl,
    output logic                busy,
    output logic                shift_req,
    output logic                unload_valid
);
    import esp_pkg::*;

    localparam int MAXC = (N > SETTLE) ? N : SETTLE;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LAST_SH = CW'(N - 1);
    localparam logic [CW-1:0] LAST_ST = CW'(SETTLE - 1);

    seq_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // Phase register and cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next phase: each phase lasts a fixed number of cycles
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (start) state_d = ST_LOAD1;
            end
            ST_LOAD1:  if (cnt_q == LAST_SH) begin state_d = ST_SETTLE; cnt_d = '0; end
            ST_SETTLE: if (cnt_q == LAST_ST) begin state_d = ST_LOAD2;  cnt_d = '0; end
            ST_LOAD2:  if (cnt_q == LAST_SH) begin state_d = ST_LAUNCH; cnt_d = '0; end
            ST_LAUNCH: begin state_d = ST_UNLOAD; cnt_d = '0; end
            ST_UNLOAD: if (cnt_q == LAST_SH) begin state_d = ST_IDLE;   cnt_d = '0; end
            default: begin state_d = ST_IDLE; cnt_d = '0; end
        endcase
    end

    // Control decode per phase
    always_comb begin
        ctrl         = '{scan: 1'b1, en: 1'b0, hold: 1'b1, pi_sel2: 1'b0};
        shift_req    = 1'b0;
        unload_valid = 1'b0;
        busy         = (state_q != ST_IDLE);
        case (state_q)
            ST_LOAD1, ST_LOAD2: begin
                ctrl.en   = 1'b1;
                shift_req = 1'b1;
            end
            ST_SETTLE: ctrl.hold = 1'b0;
            ST_LAUNCH: begin
                ctrl = '{scan: 1'b0, en: 1'b1, hold: 1'b0, pi_sel2: 1'b1};
            end
            ST_UNLOAD: begin
                ctrl.en      = 1'b1;
                unload_valid = 1'b1;
            end
            default: ;
        endcase
    end

    // R9
    launch_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAUNCH) |=> (state_q == ST_UNLOAD));

    // R10
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_req && unload_valid));

endmodule

// File: rtl/enh_scan_path.sv
// Module: top of the two-pattern scan path; N cells chained serially, each
// driving the logic through its hold stage, plus the test sequencer.
// Assumes: manual controls are used only while the sequencer is idle.
module enh_scan_path #(
    parameter int N      = 8,
    parameter int P      = 4,
    parameter int SETTLE = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         man_scan,
    input  logic         man_en,
    input  logic         man_hold,
    input  logic         scan_in,
    output logic         scan_out,
    output logic [N-1:0] to_logic,
    input  logic [N-1:0] from_logic,
    input  logic [P-1:0] pi_v1,
    input  logic [P-1:0] pi_v2,
    output logic [P-1:0] pi_out,
    output logic         busy,
    output logic         shift_req,
    output logic         unload_valid
);
    import esp_pkg::*;

    chain_ctrl_t  seq_ctrl, act_ctrl;
    logic [N-1:0] ff_q;
    logic [N-1:0] si_vec;

    esp_seq #(.N(N), .SETTLE(SETTLE)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .ctrl         (seq_ctrl),
        .busy         (busy),
        .shift_req    (shift_req),
        .unload_valid (unload_valid)
    );

    // Control source: sequencer when busy, pins when idle
    always_comb begin
        if (busy) act_ctrl = seq_ctrl;
        else      act_ctrl = '{scan: man_scan, en: man_en, hold: man_hold, pi_sel2: 1'b0};
    end

    // Primary-input selection in step with the vector phases
    assign pi_out = act_ctrl.pi_sel2 ? pi_v2 : pi_v1;

    // Serial chain: scan_in -> cell 0 -> ... -> cell N-1 -> scan_out
    assign si_vec = {ff_q[N-2:0], scan_in};
    assign scan_out = ff_q[N-1];

    for (genvar i = 0; i < N; i++) begin : g_cell
        esp_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .scan  (act_ctrl.scan),
            .en    (act_ctrl.en),
            .hold  (act_ctrl.hold),
            .si    (si_vec[i]),
            .pi    (from_logic[i]),
            .ff_q  (ff_q[i]),
            .lat_q (to_logic[i])
        );
    end

    // R5 / R8
    v1_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && seq_ctrl.hold && $past(busy && seq_ctrl.hold)) |-> $stable(to_logic));

    // R11
    pi_v1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_ctrl.pi_sel2 |-> (pi_out == pi_v1));

endmodule

// File: tb/enh_scan_path_test.sv
`timescale 1ns/100ps
module enh_scan_path_test;
    localparam int N = 8;
    localparam int P = 4;
    localparam int SETTLE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, man_scan = 1'b0, man_en = 1'b0, man_hold = 1'b0, scan_in = 1'b0;
    logic scan_out, busy, shift_req, unload_valid;
    logic [N-1:0] to_logic, from_logic;
    logic [P-1:0] pi_v1 = '0, pi_v2 = '0, pi_out;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    // Model of the logic under test: rotate left, XOR primary inputs into both halves
    function automatic logic [N-1:0] lut(input logic [N-1:0] v, input logic [P-1:0] p);
        return {v[N-2:0], v[N-1]} ^ {p, p};
    endfunction

    assign from_logic = lut(to_logic, pi_out);

    enh_scan_path #(.N(N), .P(P), .SETTLE(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .man_scan(man_scan), .man_en(man_en),
        .man_hold(man_hold), .scan_in(scan_in), .scan_out(scan_out), .to_logic(to_logic),
        .from_logic(from_logic), .pi_v1(pi_v1), .pi_v2(pi_v2), .pi_out(pi_out),
        .busy(busy), .shift_req(shift_req), .unload_valid(unload_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    // Vector table: {v1, v2, pi1, pi2}
    localparam int NV = 4;
    localparam logic [23:0] VEC [NV] = '{
        {8'h00, 8'hFF, 4'h0, 4'hF},
        {8'hA5, 8'h3C, 4'h9, 4'h6},
        {8'h81, 8'h7E, 4'h5, 4'h5},
        {8'hF0, 8'h0F, 4'hC, 4'h1}
    };

    initial begin
        logic [N-1:0] pat, cap;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(to_logic == 0 && scan_out == 0, "R1 chain cleared", 32'(to_logic), 0);
        chk(!busy && !shift_req && !unload_valid, "R1 idle", 32'({busy, shift_req, unload_valid}), 0);

        // R2/R3/R5 manual shift under hold, nonzero parallel inputs
        pi_v1 = 4'h3;
        pat = 8'hA5;
        man_scan = 1'b1; man_en = 1'b1; man_hold = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            scan_in = pat[i];
            @(negedge clk);
            chk(to_logic == 0, "R5 hold keeps outputs during shift", 32'(to_logic), 0);
        end
        man_en = 1'b0;
        chk(scan_out == pat[N-1], "R2 first bit reaches last cell", 32'(scan_out), 32'(pat[N-1]));
        man_hold = 1'b0;
        #1;
        chk(to_logic == pat, "R2 R3 shifted pattern, parallel inputs ignored", 32'(to_logic), 32'(pat));

        // R4 enable low keeps contents in normal mode
        man_scan = 1'b0;
        repeat (3) @(negedge clk);
        chk(to_logic == pat, "R4 disabled cells keep value", 32'(to_logic), 32'(pat));

        // R3 capture in normal mode
        cap = lut(pat, pi_v1);
        man_en = 1'b1;
        @(negedge clk);
        man_en = 1'b0;
        #1;
        chk(to_logic == cap, "R3 capture in normal mode", 32'(to_logic), 32'(cap));
        man_hold = 1'b1;
        @(negedge clk);

        // Sequenced two-pattern tests
        for (int k = 0; k < NV; k++) begin
            logic [N-1:0] v1, v2, exp;
            logic [P-1:0] p1, p2;
            {v1, v2, p1, p2} = VEC[k];
            pi_v1 = p1; pi_v2 = p2;
            exp = lut(v2, p2);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy, "R6 busy after start", 32'(busy), 1);
            for (int i = N - 1; i >= 0; i--) begin
                chk(shift_req && pi_out == p1, "R6 R11 first load", 32'({shift_req, pi_out}), 32'({1'b1, p1}));
                scan_in = v1[i];
                @(negedge clk);
            end
            for (int s = 0; s < SETTLE; s++) begin
                chk(to_logic == v1 && !shift_req, "R7 first vector settles", 32'(to_logic), 32'(v1));
                @(negedge clk);
            end
            for (int i = N - 1; i >= 0; i--) begin
                chk(shift_req && to_logic == v1 && pi_out == p1, "R8 R11 first vector held",
                    32'({shift_req, to_logic, pi_out}), 32'({1'b1, v1, p1}));
                scan_in = v2[i];
                @(negedge clk);
            end
            chk(to_logic == v2 && pi_out == p2 && !shift_req, "R9 launch",
                32'({to_logic, pi_out}), 32'({v2, p2}));
            @(negedge clk);
            for (int i = N - 1; i >= 0; i--) begin
                chk(unload_valid && scan_out == exp[i], "R10 unload bit",
                    32'({unload_valid, scan_out}), 32'({1'b1, exp[i]}));
                @(negedge clk);
            end
            chk(!busy && !unload_valid, "R10 back to idle", 32'({busy, unload_valid}), 0);
            chk(pi_out == p1, "R11 idle uses first PIs", 32'(pi_out), 32'(p1));
        end

        // R1 reset again after activity
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        man_hold = 1'b0;
        #1;
        chk(to_logic == 0 && !busy, "R1 reset clears again", 32'(to_logic), 0);
        finish_run();
    end
endmodule